// File: doc/BRIEF.md
# Ping-Pong Segment Block Buffer

This block sits in front of a bit-plane entropy encoder. It collects wavelet coefficient blocks into segments and passes each finished segment to the encoder. Each block is one DC coefficient and 63 AC coefficients (3 parents, 12 children, 48 grandchildren), held in sign-magnitude form, together with a 5-bit AC bit-depth word. There are two storage banks, so one bank can fill while the encoder reads the other.

A writer accepts one whole block per cycle through a valid/ready pair. It also samples the segment length and quantization value on the first block of each segment. When the last block of a segment lands, the bank is marked full. A reader then raises `seg_req` and shows the parameters stored with that bank. While the request is up, the encoder can read any block of the bank, one block per cycle. It returns `seg_ack` when it has finished, and that frees the bank.

The writer state machine has three states. `WR_START` waits for the first block of a segment and goes to `WR_FILL` once that block is accepted. `WR_FILL` returns to `WR_START` after the final block. If the bank it would fill next is still full, it goes to `WR_BLOCKED` instead, and `WR_BLOCKED` returns to `WR_START` when a release arrives. The reader state machine has two states. `RD_IDLE` moves to `RD_PEND` when the bank it points at is full, and `RD_PEND` moves back to `RD_IDLE` on an acknowledge, which frees the bank and turns the reader to the other bank.

Top module: `seg_pingpong_buf`

## Requirements
- R1: While reset is asserted and directly after it is released, `in_ready` is 1 and `seg_req` is 0.
- R2: A block is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Coefficient k sits at bits [k*CW +: CW] of the block word: k=0 is DC, 1..3 are parents, 4..15 are children and 16..63 are grandchildren. A read with `rd_en` high and block index `rd_addr` returns the stored block and depth word unchanged, one cycle later. Reads can be issued back to back, one per cycle.
- R3: The segment length is taken from `cfg_size` on the first block of a segment only. A value below SEG_MIN (16) counts as 16, and a value above SEG_MAX counts as SEG_MAX. `cfg_size` and `cfg_quant` on the later blocks of the segment have no effect.
- R4: `seg_req` rises exactly two clock edges after the edge that accepts the final block of a segment. It then shows that segment's effective length on `req_size` and its quantization on `req_quant`, and holds both steady until the acknowledge.
- R5: Segments fill the two banks in turn and are handed to the encoder in the order they arrived.
- R6: When both banks are full, `in_ready` is 0 and nothing is written. It is 1 again in the cycle after an accepted acknowledge.
- R7: An acknowledge while `seg_req` is 0 has no effect. An acknowledge held high for two cycles frees only one bank.
- R8: An acknowledge that frees one bank and the final block of the other bank's segment can fall on the same edge, and both take effect.
- R9: After an accepted acknowledge, `seg_req` is 0 for at least one cycle before it offers the next segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Buffer can take a block |
| in_block | input | 64*CW | 64 sign-magnitude coefficients |
| in_depth | input | 5 | AC bit-depth of the block |
| cfg_size | input | $clog2(SEG_MAX+1) | Segment length, used on the first block |
| cfg_quant | input | QW | Quantization value, used on the first block |
| seg_req | output | 1 | A full segment is ready for the encoder |
| seg_ack | input | 1 | Encoder has finished the offered segment |
| req_size | output | $clog2(SEG_MAX+1) | Effective length of the offered segment |
| req_quant | output | QW | Quantization value of the offered segment |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(SEG_MAX) | Block index within the offered bank |
| rd_block | output | 64*CW | Block read, one cycle after `rd_en` |
| rd_depth | output | 5 | Depth word read, one cycle after `rd_en` |

## Verification
Two functions can fall on the same clock edge. One is the release of the bank being drained. The other is the completion of the segment filling the second bank. The bench drives the sixteenth block of a segment in the same cycle as `seg_ack`. It then expects `in_ready` to stay high, `seg_req` to drop for exactly one cycle, and the new segment to be offered with its own parameters and intact data. A second test holds the acknowledge for two cycles and checks that the bank behind it stays full and is offered again.

// File: rtl/seg_buf_pkg.sv
package seg_buf_pkg;

    localparam int NCOEF   = 64;
    localparam int DEPTH_W = 5;
    localparam int NBANK   = 2;

    typedef enum logic [1:0] {
        WR_START   = 2'd0,
        WR_FILL    = 2'd1,
        WR_BLOCKED = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_PEND = 1'b1
    } rd_state_e;

endpackage

// File: rtl/seg_bank_ram.sv
module seg_bank_ram #(
    parameter int ENT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENT_W-1:0]  rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [ENT_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/seg_wr_ctrl.sv
module seg_wr_ctrl
    import seg_buf_pkg::*;
#(
    parameter int SEG_MIN = 16,
    parameter int SEG_MAX = 128,
    parameter int QW      = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [$clog2(SEG_MAX+1)-1:0] cfg_size,
    input  logic [QW-1:0]                cfg_quant,
    input  logic [NBANK-1:0]             bank_full,
    input  logic                         rel_fire,
    input  logic                         rel_bank,
    output logic                         in_ready,
    output logic                         wr_en,
    output logic                         wr_bank,
    output logic [$clog2(SEG_MAX)-1:0]   wr_addr,
    output logic                         seg_done,
    output logic [$clog2(SEG_MAX+1)-1:0] done_size,
    output logic [QW-1:0]                done_quant
);
    localparam int AW  = $clog2(SEG_MAX);
    localparam int SZW = $clog2(SEG_MAX + 1);

    wr_state_e       state_q, state_d;
    logic            wbank_q;
    logic [AW-1:0]   cnt_q;
    logic [SZW-1:0]  cur_size_q;
    logic [QW-1:0]   cur_quant_q;
    logic [SZW-1:0]  eff_size;
    logic [SZW-1:0]  size_now;
    logic            last_blk;
    logic            other_busy;

    always_comb begin
        if (cfg_size < SZW'(SEG_MIN)) begin
            eff_size = SZW'(SEG_MIN);
        end else if (cfg_size > SZW'(SEG_MAX)) begin
            eff_size = SZW'(SEG_MAX);
        end else begin
            eff_size = cfg_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_START;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        size_now   = (state_q == WR_START) ? eff_size : cur_size_q;
        done_quant = (state_q == WR_START) ? cfg_quant : cur_quant_q;
        in_ready   = (state_q != WR_BLOCKED);
        wr_en      = in_valid && in_ready;
        last_blk   = (SZW'(cnt_q) == size_now - SZW'(1));
        seg_done   = wr_en && last_blk;
        other_busy = bank_full[~wbank_q] && !(rel_fire && (rel_bank == ~wbank_q));
        done_size  = size_now;
        wr_bank    = wbank_q;
        wr_addr    = cnt_q;
        state_d    = state_q;
        unique case (state_q)
            WR_START: begin
                if (wr_en) begin
                    if (seg_done) begin
                        state_d = other_busy ? WR_BLOCKED : WR_START;
                    end else begin
                        state_d = WR_FILL;
                    end
                end
            end
            WR_FILL: begin
                if (seg_done) begin
                    state_d = other_busy ? WR_BLOCKED : WR_START;
                end
            end
            WR_BLOCKED: begin
                if (rel_fire) begin
                    state_d = WR_START;
                end
            end
            default: state_d = WR_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbank_q     <= 1'b0;
            cnt_q       <= '0;
            cur_size_q  <= SZW'(SEG_MIN);
            cur_quant_q <= '0;
        end else begin
            if (wr_en) begin
                cnt_q <= seg_done ? '0 : cnt_q + AW'(1);
            end
            if (wr_en && state_q == WR_START) begin
                cur_size_q  <= eff_size;
                cur_quant_q <= cfg_quant;
            end
            if (seg_done) begin
                wbank_q <= ~wbank_q;
            end
        end
    end

    // R3
    size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WR_START) |-> (cur_size_q >= SZW'(SEG_MIN) && cur_size_q <= SZW'(SEG_MAX)));

    // R6
    blocked_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_BLOCKED) |-> bank_full[wbank_q]);
endmodule

// File: rtl/seg_rd_ctrl.sv
module seg_rd_ctrl
    import seg_buf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_done,
    input  logic             done_bank,
    input  logic             seg_ack,
    output logic             seg_req,
    output logic             rd_bank,
    output logic             rel_fire,
    output logic [NBANK-1:0] bank_full
);
    rd_state_e state_q, state_d;
    logic      rbank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        seg_req  = (state_q == RD_PEND);
        rel_fire = (state_q == RD_PEND) && seg_ack;
        rd_bank  = rbank_q;
        state_d  = state_q;
        unique case (state_q)
            RD_IDLE: if (bank_full[rbank_q]) state_d = RD_PEND;
            RD_PEND: if (seg_ack)            state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbank_q <= 1'b0;
        end else if (rel_fire) begin
            rbank_q <= ~rbank_q;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_full
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_full[b] <= 1'b0;
            end else if (seg_done && done_bank == 1'(b)) begin
                bank_full[b] <= 1'b1;
            end else if (rel_fire && rbank_q == 1'(b)) begin
                bank_full[b] <= 1'b0;
            end
        end
    end

    // R7
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_fire |=> !rel_fire);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_req && !seg_ack) |=> seg_req);

    // R9
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_fire |=> !seg_req);
endmodule

// File: rtl/seg_pingpong_buf.sv
module seg_pingpong_buf
    import seg_buf_pkg::*;
#(
    parameter int CW      = 28,
    parameter int SEG_MIN = 16,
    parameter int SEG_MAX = 128,
    parameter int QW      = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [NCOEF*CW-1:0]          in_block,
    input  logic [DEPTH_W-1:0]           in_depth,
    input  logic [$clog2(SEG_MAX+1)-1:0] cfg_size,
    input  logic [QW-1:0]                cfg_quant,
    output logic                         seg_req,
    input  logic                         seg_ack,
    output logic [$clog2(SEG_MAX+1)-1:0] req_size,
    output logic [QW-1:0]                req_quant,
    input  logic                         rd_en,
    input  logic [$clog2(SEG_MAX)-1:0]   rd_addr,
    output logic [NCOEF*CW-1:0]          rd_block,
    output logic [DEPTH_W-1:0]           rd_depth
);
    localparam int BLK_W = NCOEF * CW;
    localparam int ENT_W = BLK_W + DEPTH_W;
    localparam int AW    = $clog2(SEG_MAX);
    localparam int SZW   = $clog2(SEG_MAX + 1);

    logic             wr_en, wr_bank, seg_done;
    logic [AW-1:0]    wr_addr;
    logic [SZW-1:0]   done_size;
    logic [QW-1:0]    done_quant;
    logic             rel_fire, rd_bank;
    logic [NBANK-1:0] bank_full;
    logic [ENT_W-1:0] rdata;
    logic [SZW-1:0]   size_bank  [NBANK];
    logic [QW-1:0]    quant_bank [NBANK];

    seg_wr_ctrl #(.SEG_MIN(SEG_MIN), .SEG_MAX(SEG_MAX), .QW(QW)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cfg_size(cfg_size), .cfg_quant(cfg_quant),
        .bank_full(bank_full), .rel_fire(rel_fire), .rel_bank(rd_bank),
        .in_ready(in_ready), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .seg_done(seg_done), .done_size(done_size), .done_quant(done_quant)
    );

    seg_rd_ctrl u_rd (
        .clk(clk), .rst_n(rst_n), .seg_done(seg_done), .done_bank(wr_bank),
        .seg_ack(seg_ack), .seg_req(seg_req), .rd_bank(rd_bank),
        .rel_fire(rel_fire), .bank_full(bank_full)
    );

    seg_bank_ram #(.ENT_W(ENT_W), .ADDR_W(AW + 1)) u_ram (
        .clk(clk), .we(wr_en), .waddr({wr_bank, wr_addr}), .wdata({in_depth, in_block}),
        .re(rd_en), .raddr({rd_bank, rd_addr}), .rdata(rdata)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_par
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_bank[b]  <= '0;
                quant_bank[b] <= '0;
            end else if (seg_done && wr_bank == 1'(b)) begin
                size_bank[b]  <= done_size;
                quant_bank[b] <= done_quant;
            end
        end
    end

    always_comb begin
        req_size  = size_bank[rd_bank];
        req_quant = quant_bank[rd_bank];
        rd_block  = rdata[BLK_W-1:0];
        rd_depth  = rdata[ENT_W-1 -: DEPTH_W];
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bank_full[wr_bank]);

    // R4
    param_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_req && !seg_ack) |=> ($stable(req_size) && $stable(req_quant)));

    // R8
    no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_done && rel_fire) |-> (wr_bank != rd_bank));
endmodule

// File: tb/test_seg_pingpong_buf.sv
module test_seg_pingpong_buf;
    localparam int CW    = 28;
    localparam int BLK_W = 64 * CW;
    localparam int SZW   = 8;
    localparam int AW    = 7;
    localparam int QW    = 5;

    // fields: [20:13] cfg_size, [12:8] cfg_quant, [7:0] effective size
    localparam logic [20:0] SEG_TAB [6] = '{
        {8'd16,  5'd3,  8'd16},
        {8'd5,   5'd7,  8'd16},
        {8'd40,  5'd1,  8'd40},
        {8'd200, 5'd31, 8'd128},
        {8'd16,  5'd0,  8'd16},
        {8'd128, 5'd12, 8'd128}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [BLK_W-1:0] in_block = '0;
    logic [4:0]       in_depth = '0;
    logic [SZW-1:0]   cfg_size = '0;
    logic [QW-1:0]    cfg_quant = '0;
    logic             seg_req;
    logic             seg_ack = 1'b0;
    logic [SZW-1:0]   req_size;
    logic [QW-1:0]    req_quant;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [BLK_W-1:0] rd_block;
    logic [4:0]       rd_depth;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    seg_pingpong_buf i_seg_pingpong_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_block(in_block), .in_depth(in_depth), .cfg_size(cfg_size), .cfg_quant(cfg_quant),
        .seg_req(seg_req), .seg_ack(seg_ack), .req_size(req_size), .req_quant(req_quant),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_block(rd_block), .rd_depth(rd_depth)
    );

    function automatic logic [BLK_W-1:0] pat(input int id, input int idx);
        logic [BLK_W-1:0] r;
        for (int k = 0; k < 64; k++) begin
            r[k*CW +: CW] = CW'((id * 40503) ^ (idx << 9) ^ (k * 69) ^ (k << 20));
        end
        return r;
    endfunction

    function automatic logic [4:0] dep(input int id, input int idx);
        return 5'((id * 3 + idx) % 32);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; seg_ack = 1'b0; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1 && seg_req == 1'b0, "R1 during reset", {in_ready, seg_req}, 2'b10);
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b1 && seg_req == 1'b0, "R1 after reset", {in_ready, seg_req}, 2'b10);
    endtask

    task automatic put(input int id, input int idx, input logic [SZW-1:0] sz, input logic [QW-1:0] q);
        @(negedge clk);
        in_valid = 1'b1; in_block = pat(id, idx); in_depth = dep(id, idx);
        cfg_size = sz; cfg_quant = q;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic read_seg(input int id, input int n, input string tag);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(rd_block == pat(id, i - 1) && rd_depth == dep(id, i - 1), tag,
                    rd_block[63:0] ^ 64'(rd_depth), pat(id, i - 1)[63:0] ^ 64'(dep(id, i - 1)));
            end
            if (i < n) begin
                rd_en = 1'b1; rd_addr = AW'(i);
                @(posedge clk);
            end else begin
                rd_en = 1'b0;
            end
        end
    endtask

    task automatic wait_req();
        while (!seg_req) @(negedge clk);
    endtask

    task automatic ack_pulse();
        @(negedge clk); seg_ack = 1'b1;
        @(posedge clk);
        @(negedge clk); seg_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: R3 clamping, R5 ordering, R2 data, R9 gap, R6 natural stalls
        fork
            begin
                for (int s = 0; s < 6; s++) begin
                    for (int i = 0; i < int'(SEG_TAB[s][7:0]); i++) begin
                        if (i == 0) put(s + 1, i, SEG_TAB[s][20:13], SEG_TAB[s][12:8]);
                        else        put(s + 1, i, 8'd3, ~SEG_TAB[s][12:8]);
                    end
                end
                @(negedge clk); in_valid = 1'b0;
            end
            begin
                for (int s = 0; s < 6; s++) begin
                    wait_req();
                    chk(req_size == SEG_TAB[s][7:0], "R3 R5 req_size", 64'(req_size), 64'(SEG_TAB[s][7:0]));
                    chk(req_quant == SEG_TAB[s][12:8], "R3 R5 req_quant", 64'(req_quant), 64'(SEG_TAB[s][12:8]));
                    read_seg(s + 1, int'(SEG_TAB[s][7:0]), "R2 R5 block data");
                    ack_pulse();
                    chk(seg_req == 1'b0, "R9 gap after ack", 64'(seg_req), 64'd0);
                end
            end
        join

        // R7: ack with no request pending, then R4 request timing
        do_reset();
        ack_pulse();
        chk(seg_req == 1'b0, "R7 idle ack", 64'(seg_req), 64'd0);
        for (int i = 0; i < 16; i++) put(20, i, 8'd16, 5'd9);
        @(negedge clk); in_valid = 1'b0;
        chk(seg_req == 1'b0, "R4 req not one edge after", 64'(seg_req), 64'd0);
        @(posedge clk); @(negedge clk);
        chk(seg_req == 1'b1, "R4 req two edges after", 64'(seg_req), 64'd1);
        chk(req_size == 8'd16 && req_quant == 5'd9, "R4 params", {req_size, 3'b0, req_quant}, {8'd16, 3'b0, 5'd9});

        // R6: second segment fills other bank, writer stalls
        for (int i = 0; i < 20; i++) put(21, i, 8'd20, 5'd2);
        @(negedge clk);
        chk(in_ready == 1'b0, "R6 both full", 64'(in_ready), 64'd0);
        chk(req_size == 8'd16, "R5 first segment still offered", 64'(req_size), 64'd16);
        in_valid = 1'b1; in_block = pat(99, 0); in_depth = 5'd1; cfg_size = 8'd16;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R6 stall holds", 64'(in_ready), 64'd0);
        end
        in_valid = 1'b0;
        read_seg(20, 16, "R6 first bank intact");

        // R7: ack held two cycles frees one bank only
        @(negedge clk); seg_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(in_ready == 1'b1, "R6 ready after ack", 64'(in_ready), 64'd1);
        chk(seg_req == 1'b0, "R9 gap", 64'(seg_req), 64'd0);
        @(posedge clk); @(negedge clk); seg_ack = 1'b0;
        chk(seg_req == 1'b1 && req_size == 8'd20, "R7 double ack frees one bank",
            {seg_req, req_size}, {1'b1, 8'd20});
        read_seg(21, 20, "R6 R7 second bank intact");

        // R8: final block and release of the other bank on one edge
        for (int i = 0; i < 15; i++) put(22, i, 8'd16, 5'd17);
        @(negedge clk);
        in_valid = 1'b1; in_block = pat(22, 15); in_depth = dep(22, 15); seg_ack = 1'b1;
        chk(in_ready == 1'b1, "R8 ready before edge", 64'(in_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        seg_ack = 1'b0; in_valid = 1'b0;
        chk(in_ready == 1'b1, "R8 writer not blocked", 64'(in_ready), 64'd1);
        chk(seg_req == 1'b0, "R8 req gap", 64'(seg_req), 64'd0);
        @(posedge clk); @(negedge clk);
        chk(seg_req == 1'b1 && req_size == 8'd16 && req_quant == 5'd17, "R8 new segment offered",
            {seg_req, req_size, req_quant}, {1'b1, 8'd16, 5'd17});
        read_seg(22, 16, "R8 block data");
        ack_pulse();
        chk(seg_req == 1'b0 && in_ready == 1'b1, "R7 R9 all free", {seg_req, in_ready}, 2'b01);
        repeat (3) @(negedge clk);
        chk(seg_req == 1'b0, "R7 no stale request", 64'(seg_req), 64'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule